// File: doc/BRIEF.md
# Transmit Descriptor Ring Walker

This block reads transmit entries from a descriptor ring. The ring arrives as a stream of 64-bit little-endian words. Every entry opens with a 16-byte header. The header states two sizes up front: the length of an optional inline region, and the number of 16-byte data descriptors that close the entry. Because both sizes are declared, the walker always knows where a packet ends. It never follows a chain or scans for a terminator.

From each entry the walker produces up to four results, each on its own valid/ready output:
- the decoded offload metadata, one beat per entry;
- the inline bytes as a byte-enabled word stream;
- one beat per data descriptor, giving its address, length, id and flags;
- a completion that returns the header id once the entry has been fully consumed.

If the header declares an inline region longer than the limit, the walker still skips the entry using its declared sizes. For such an entry it emits only a completion, with the error bit set. Back-pressure on any output holds the input stream, so no bytes are lost.

The control is one state machine with these states:
- `HDR_LO`: takes the first header word and goes to `HDR_HI`.
- `HDR_HI`: takes the second header word. A well-formed header goes to `META`. An oversized header goes to the first region that is present (`INLINE`, then `DSC_ADDR`, then `CPL`).
- `META`: offers the metadata. On acceptance it goes to the first region that is present.
- `INLINE`: passes the inline words through. After the last one it goes to `DSC_ADDR` if descriptors are declared, otherwise to `CPL`.
- `DSC_ADDR`: captures a descriptor's address word and goes to `DSC_REST`.
- `DSC_REST`: offers the completed descriptor. It loops back to `DSC_ADDR` until the count is used up, then goes to `CPL`.
- `CPL`: offers the completion and returns to `HDR_LO` when it is accepted.

Top module: `txw_walker`

## Requirements
- R1: Header word 0 holds flags in bits [15:0], id in [31:16], descriptor count in [39:32], segmentation type in [47:40] and segmentation header length in [63:48]. Header word 1 holds segment size in [15:0], checksum start in [31:16], checksum offset in [47:32] and inline length in [55:48]; bits [63:56] are ignored. For every well-formed entry, exactly one metadata beat carries these fields, before any inline or descriptor beat of that entry.
- R2: An inline length L is carried as ceil(L/8) inline beats. Each beat passes its input word through unchanged. Only the final beat of the entry raises `inl_last`.
- R3: The byte-enable mask is 0xFF on every inline beat except the final one. On the final beat, bit b is set when b < (L mod 8), or all bits are set when L mod 8 is 0.
- R4: Data descriptors begin at the first word after the last inline word, which is the next 8-byte boundary. Each descriptor is two words: the address in word 0, then length [31:0], id [47:32] and flags [63:48] in word 1. Exactly as many descriptor beats are produced as the header declares.
- R5: `dsc_last` is high only on the final descriptor beat of an entry.
- R6: After the last word of an entry has been consumed, exactly one completion carries the header id. For a well-formed entry it has `cpl_err` low.
- R7: An inline length above 128 produces no metadata, inline or descriptor beat. The declared inline and descriptor words are consumed and discarded, and the completion carries `cpl_err` high. The entry that follows is decoded correctly.
- R8: Inline length 0 and descriptor count 0 are legal. A header-only entry yields one metadata beat and then its completion.
- R9: While an output is valid but not ready, its valid stays high and its payload stays unchanged. While a completion is pending, no input word is accepted.
- R10: At most one of the four output valids is high in any cycle.
- R11: After reset, the walker accepts input and drives every output valid low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Ring word available |
| in_ready | output | 1 | Ring word accepted this cycle |
| in_data | input | 64 | Ring word, little-endian |
| meta_valid | output | 1 | Metadata beat valid |
| meta_ready | input | 1 | Metadata beat taken |
| meta_flags | output | 16 | Header flags |
| meta_gso_type | output | 8 | Segmentation type |
| meta_gso_hdr_len | output | 16 | Segmentation header length |
| meta_gso_size | output | 16 | Segment size |
| meta_csum_start | output | 16 | Checksum start offset |
| meta_csum_offset | output | 16 | Checksum placement offset |
| meta_inline_len | output | 8 | Inline byte count |
| meta_desc_cnt | output | 8 | Data descriptor count |
| inl_valid | output | 1 | Inline beat valid |
| inl_ready | input | 1 | Inline beat taken |
| inl_data | output | 64 | Inline bytes |
| inl_keep | output | 8 | Byte enables |
| inl_last | output | 1 | Final inline beat |
| dsc_valid | output | 1 | Descriptor beat valid |
| dsc_ready | input | 1 | Descriptor beat taken |
| dsc_addr | output | 64 | Buffer address |
| dsc_len | output | 32 | Buffer length |
| dsc_id | output | 16 | Descriptor id |
| dsc_flags | output | 16 | Descriptor flags |
| dsc_last | output | 1 | Final descriptor of entry |
| cpl_valid | output | 1 | Completion valid |
| cpl_ready | input | 1 | Completion taken |
| cpl_id | output | 16 | Header id returned |
| cpl_err | output | 1 | Entry was malformed |

## Verification
The assertions check four properties on every cycle:
- at most one output valid is high at a time;
- stalled metadata and completions hold their payload;
- the shape of the byte-enable mask;
- input is refused while a completion is pending, and a completion follows the final descriptor.

The bench sweeps every inline length from 0 to 136 and several lengths above the limit, with descriptor counts from 0 to 3 and irregular back-pressure on every port. Only these scenarios can show that field positions, beat counts, the realignment after an unaligned inline tail, the skipping of error entries and the returned ids match arithmetic expectations.

// File: rtl/txw_pkg.sv
package txw_pkg;
    localparam int WORD_BYTES = 8;
    localparam int WORD_W     = WORD_BYTES * 8;
    localparam int LEN_W      = 8;
    localparam int ICNT_W     = $clog2(((1 << LEN_W) + WORD_BYTES - 1) / WORD_BYTES + 1);

    typedef enum logic [2:0] {
        HDR_LO, HDR_HI, META, INLINE, DSC_ADDR, DSC_REST, CPL
    } wstate_t;

    typedef struct packed {
        logic [15:0]      flags;
        logic [15:0]      id;
        logic [LEN_W-1:0] ndesc;
        logic [7:0]       gso_type;
        logic [15:0]      gso_hdr_len;
        logic [15:0]      gso_size;
        logic [15:0]      csum_start;
        logic [15:0]      csum_offset;
        logic [LEN_W-1:0] inline_len;
    } hdr_t;

    typedef struct packed {
        logic [WORD_W-1:0] addr;
        logic [31:0]       len;
        logic [15:0]       id;
        logic [15:0]       flags;
    } dsc_t;

    function automatic wstate_t after_inline(input logic [LEN_W-1:0] nd);
        return (nd != '0) ? DSC_ADDR : CPL;
    endfunction

    function automatic wstate_t after_header(input logic [LEN_W-1:0] il,
                                             input logic [LEN_W-1:0] nd);
        return (il != '0) ? INLINE : after_inline(nd);
    endfunction
endpackage

// File: rtl/txw_hdr_unpack.sv
module txw_hdr_unpack
    import txw_pkg::*;
(
    input  logic [WORD_W-1:0] word_lo,
    input  logic [WORD_W-1:0] word_hi,
    output hdr_t              hdr
);
    always_comb begin
        hdr.flags       = word_lo[15:0];
        hdr.id          = word_lo[31:16];
        hdr.ndesc       = word_lo[39:32];
        hdr.gso_type    = word_lo[47:40];
        hdr.gso_hdr_len = word_lo[63:48];
        hdr.gso_size    = word_hi[15:0];
        hdr.csum_start  = word_hi[31:16];
        hdr.csum_offset = word_hi[47:32];
        hdr.inline_len  = word_hi[55:48];
    end
endmodule

// File: rtl/txw_span_calc.sv
module txw_span_calc
    import txw_pkg::*;
#(
    parameter int MAX_INLINE = 128
) (
    input  logic [LEN_W-1:0]      len,
    output logic [ICNT_W-1:0]     words,
    output logic [WORD_BYTES-1:0] last_keep,
    output logic                  too_long
);
    localparam int REM_W = $clog2(WORD_BYTES);

    logic [REM_W-1:0] rem;
    logic [LEN_W:0]   rounded;

    assign rem      = len[REM_W-1:0];
    assign rounded  = {1'b0, len} + (LEN_W+1)'(WORD_BYTES - 1);
    assign words    = ICNT_W'(rounded >> REM_W);
    assign too_long = ({1'b0, len} > (LEN_W+1)'(MAX_INLINE));

    for (genvar b = 0; b < WORD_BYTES; b++) begin : g_keep
        assign last_keep[b] = (rem == '0) || (REM_W'(b) < rem);
    end
endmodule

// File: rtl/txw_dsc_unpack.sv
module txw_dsc_unpack
    import txw_pkg::*;
(
    input  logic [WORD_W-1:0] word_a,
    input  logic [WORD_W-1:0] word_b,
    output dsc_t              dsc
);
    always_comb begin
        dsc.addr  = word_a;
        dsc.len   = word_b[31:0];
        dsc.id    = word_b[47:32];
        dsc.flags = word_b[63:48];
    end
endmodule

// File: rtl/txw_walker.sv
module txw_walker
    import txw_pkg::*;
#(
    parameter int MAX_INLINE = 128
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        in_valid,
    output logic        in_ready,
    input  logic [63:0] in_data,
    output logic        meta_valid,
    input  logic        meta_ready,
    output logic [15:0] meta_flags,
    output logic [7:0]  meta_gso_type,
    output logic [15:0] meta_gso_hdr_len,
    output logic [15:0] meta_gso_size,
    output logic [15:0] meta_csum_start,
    output logic [15:0] meta_csum_offset,
    output logic [7:0]  meta_inline_len,
    output logic [7:0]  meta_desc_cnt,
    output logic        inl_valid,
    input  logic        inl_ready,
    output logic [63:0] inl_data,
    output logic [7:0]  inl_keep,
    output logic        inl_last,
    output logic        dsc_valid,
    input  logic        dsc_ready,
    output logic [63:0] dsc_addr,
    output logic [31:0] dsc_len,
    output logic [15:0] dsc_id,
    output logic [15:0] dsc_flags,
    output logic        dsc_last,
    output logic        cpl_valid,
    input  logic        cpl_ready,
    output logic [15:0] cpl_id,
    output logic        cpl_err
);
    wstate_t               state_q, state_d;
    logic [WORD_W-1:0]     lo_q;
    logic [WORD_W-1:0]     addr_q;
    hdr_t                  hdr_q;
    hdr_t                  hdr_new;
    dsc_t                  dsc_cur;
    logic                  err_q;
    logic [ICNT_W-1:0]     icnt_q;
    logic [LEN_W-1:0]      dcnt_q;
    logic [WORD_BYTES-1:0] keep_q;
    logic [ICNT_W-1:0]     span_words;
    logic [WORD_BYTES-1:0] span_keep;
    logic                  span_bad;
    logic                  take;
    logic                  inl_end;
    logic                  dsc_end;

    txw_hdr_unpack u_hdr (
        .word_lo (lo_q),
        .word_hi (in_data),
        .hdr     (hdr_new)
    );

    txw_span_calc #(.MAX_INLINE(MAX_INLINE)) u_span (
        .len       (hdr_new.inline_len),
        .words     (span_words),
        .last_keep (span_keep),
        .too_long  (span_bad)
    );

    txw_dsc_unpack u_dsc (
        .word_a (addr_q),
        .word_b (in_data),
        .dsc    (dsc_cur)
    );

    assign take    = in_valid && in_ready;
    assign inl_end = (icnt_q == ICNT_W'(1));
    assign dsc_end = (dcnt_q == LEN_W'(1));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= HDR_LO;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            HDR_LO:   if (take) state_d = HDR_HI;
            HDR_HI:   if (take) state_d = span_bad
                                    ? after_header(hdr_new.inline_len, hdr_new.ndesc)
                                    : META;
            META:     if (meta_ready) state_d = after_header(hdr_q.inline_len, hdr_q.ndesc);
            INLINE:   if (take && inl_end) state_d = after_inline(hdr_q.ndesc);
            DSC_ADDR: if (take) state_d = DSC_REST;
            DSC_REST: if (take) state_d = dsc_end ? CPL : DSC_ADDR;
            CPL:      if (cpl_ready) state_d = HDR_LO;
            default:  state_d = HDR_LO;
        endcase
    end

    // outputs
    always_comb begin
        in_ready   = 1'b0;
        meta_valid = 1'b0;
        inl_valid  = 1'b0;
        dsc_valid  = 1'b0;
        cpl_valid  = 1'b0;
        unique case (state_q)
            HDR_LO, HDR_HI, DSC_ADDR: in_ready = 1'b1;
            META:     meta_valid = 1'b1;
            INLINE: begin
                in_ready  = err_q ? 1'b1 : inl_ready;
                inl_valid = in_valid && !err_q;
            end
            DSC_REST: begin
                in_ready  = err_q ? 1'b1 : dsc_ready;
                dsc_valid = in_valid && !err_q;
            end
            CPL:      cpl_valid = 1'b1;
            default:  in_ready = 1'b0;
        endcase
        meta_flags       = hdr_q.flags;
        meta_gso_type    = hdr_q.gso_type;
        meta_gso_hdr_len = hdr_q.gso_hdr_len;
        meta_gso_size    = hdr_q.gso_size;
        meta_csum_start  = hdr_q.csum_start;
        meta_csum_offset = hdr_q.csum_offset;
        meta_inline_len  = hdr_q.inline_len;
        meta_desc_cnt    = hdr_q.ndesc;
        inl_data         = in_data;
        inl_last         = inl_end;
        inl_keep         = inl_end ? keep_q : '1;
        dsc_addr         = dsc_cur.addr;
        dsc_len          = dsc_cur.len;
        dsc_id           = dsc_cur.id;
        dsc_flags        = dsc_cur.flags;
        dsc_last         = dsc_end;
        cpl_id           = hdr_q.id;
        cpl_err          = err_q;
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lo_q   <= '0;
            addr_q <= '0;
            hdr_q  <= '0;
            err_q  <= 1'b0;
            icnt_q <= '0;
            dcnt_q <= '0;
            keep_q <= '0;
        end else if (take) begin
            unique case (state_q)
                HDR_LO:   lo_q <= in_data;
                HDR_HI: begin
                    hdr_q  <= hdr_new;
                    err_q  <= span_bad;
                    icnt_q <= span_words;
                    dcnt_q <= hdr_new.ndesc;
                    keep_q <= span_keep;
                end
                INLINE:   icnt_q <= icnt_q - ICNT_W'(1);
                DSC_ADDR: addr_q <= in_data;
                DSC_REST: dcnt_q <= dcnt_q - LEN_W'(1);
                default:  ;
            endcase
        end
    end
endmodule

// File: rtl/txw_walker_chk.sv
module txw_walker_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        in_ready,
    input logic        meta_valid,
    input logic        meta_ready,
    input logic [15:0] meta_flags,
    input logic [7:0]  meta_inline_len,
    input logic [7:0]  meta_desc_cnt,
    input logic        inl_valid,
    input logic [7:0]  inl_keep,
    input logic        inl_last,
    input logic        dsc_valid,
    input logic        dsc_ready,
    input logic        dsc_last,
    input logic        cpl_valid,
    input logic        cpl_ready,
    input logic [15:0] cpl_id,
    input logic        cpl_err
);
    a_r10_one_valid: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({meta_valid, inl_valid, dsc_valid, cpl_valid}));

    a_r9_meta_hold: assert property (@(posedge clk) disable iff (!rst_n)
        meta_valid && !meta_ready |=> meta_valid && $stable(meta_flags)
            && $stable(meta_inline_len) && $stable(meta_desc_cnt));

    a_r9_cpl_hold: assert property (@(posedge clk) disable iff (!rst_n)
        cpl_valid && !cpl_ready |=> cpl_valid && $stable(cpl_id) && $stable(cpl_err));

    a_r9_no_take_in_cpl: assert property (@(posedge clk) disable iff (!rst_n)
        cpl_valid |-> !in_ready);

    a_r3_keep_full: assert property (@(posedge clk) disable iff (!rst_n)
        inl_valid && !inl_last |-> inl_keep == 8'hFF);

    a_r3_keep_shape: assert property (@(posedge clk) disable iff (!rst_n)
        inl_valid |-> inl_keep[0] && ((inl_keep & (inl_keep + 8'd1)) == 8'h00));

    a_r6_cpl_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        dsc_valid && dsc_ready && dsc_last |=> cpl_valid);
endmodule

bind txw_walker txw_walker_chk u_chk (.*);

// File: tb/txw_walker_test.sv
`timescale 1ns/1ps
module txw_walker_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic        in_valid = 1'b0, in_ready;
    logic [63:0] in_data = '0;
    logic        meta_valid, meta_ready = 1'b0;
    logic [15:0] meta_flags, meta_gso_hdr_len, meta_gso_size, meta_csum_start, meta_csum_offset;
    logic [7:0]  meta_gso_type, meta_inline_len, meta_desc_cnt;
    logic        inl_valid, inl_ready = 1'b0, inl_last;
    logic [63:0] inl_data;
    logic [7:0]  inl_keep;
    logic        dsc_valid, dsc_ready = 1'b0, dsc_last;
    logic [63:0] dsc_addr;
    logic [31:0] dsc_len;
    logic [15:0] dsc_id, dsc_flags;
    logic        cpl_valid, cpl_ready = 1'b0, cpl_err;
    logic [15:0] cpl_id;

    txw_walker uut (.*);

    int checks = 0, fails = 0;
    logic [63:0]  words[$];
    logic [103:0] exp_meta[$];
    logic [72:0]  exp_inl[$];
    logic [128:0] exp_dsc[$];
    logic [16:0]  exp_cpl[$];
    int  idx = 0;
    bit  run = 0;
    bit  accepted = 0;
    logic [15:0] lfsr = 16'hACE1;

    task automatic chk(input string tag, input logic [255:0] got, input logic [255:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s got %h exp %h", tag, got, exp);
        end
    endtask

    task automatic add_entry(input int id, input int ilen, input int nd);
        logic [15:0] fl, ghl, gsz, cs, co;
        logic [7:0]  gt;
        bit err;
        int nw;
        fl = 16'h1000 + 16'(id); gt = 8'(id) ^ 8'h5A; ghl = 16'(id * 3);
        gsz = 16'(1400 + id); cs = 16'(14 + id); co = 16'(id * 2 + 6);
        err = ilen > 128;
        words.push_back({ghl, gt, 8'(nd), 16'(id), fl});
        words.push_back({8'hA5, 8'(ilen), co, cs, gsz});
        if (!err) exp_meta.push_back({fl, gt, ghl, gsz, cs, co, 8'(ilen), 8'(nd)});
        nw = (ilen + 7) / 8;
        for (int k = 0; k < nw; k++) begin
            logic [63:0] w;
            logic [7:0]  kp;
            for (int j = 0; j < 8; j++)
                w[j*8 +: 8] = (k*8 + j < ilen) ? 8'(id*7 + k*8 + j) : 8'hEE;
            kp = 8'hFF;
            if (k == nw - 1 && ilen % 8 != 0) kp = 8'((1 << (ilen % 8)) - 1);
            words.push_back(w);
            if (!err) exp_inl.push_back({w, kp, k == nw - 1});
        end
        for (int d = 0; d < nd; d++) begin
            logic [63:0] a;
            logic [31:0] ln;
            logic [15:0] di, df;
            a = {32'h8000_0000 + 32'(id), 16'(d), 16'hBEEF};
            ln = 32'(64 * (d + 1) + id); di = 16'(id * 16 + d); df = 16'(d + 3);
            words.push_back(a);
            words.push_back({df, di, ln});
            if (!err) exp_dsc.push_back({a, ln, di, df, d == nd - 1});
        end
        exp_cpl.push_back({16'(id), err});
    endtask

    // stall-hold bookkeeping (R9)
    bit m_st = 0, d_st = 0, c_st = 0, i_st = 0;
    logic [103:0] m_hold; logic [128:0] d_hold; logic [16:0] c_hold; logic [72:0] i_hold;

    always begin
        @(negedge clk);
        if (run) begin
            if (accepted) begin idx++; in_valid = 1'b0; accepted = 0; end
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            meta_ready = lfsr[0] | lfsr[1];
            inl_ready  = lfsr[2] | lfsr[3];
            dsc_ready  = lfsr[4] | lfsr[7];
            cpl_ready  = lfsr[8] & lfsr[9] | lfsr[11];
            if (!in_valid && idx < words.size()) in_valid = lfsr[5] | lfsr[6];
            if (idx < words.size()) in_data = words[idx];
            #8;
            begin
                logic [103:0] mv; logic [72:0] iv; logic [128:0] dv; logic [16:0] cv;
                mv = {meta_flags, meta_gso_type, meta_gso_hdr_len, meta_gso_size,
                      meta_csum_start, meta_csum_offset, meta_inline_len, meta_desc_cnt};
                iv = {inl_data, inl_keep, inl_last};
                dv = {dsc_addr, dsc_len, dsc_id, dsc_flags, dsc_last};
                cv = {cpl_id, cpl_err};
                // R10 one output at a time
                chk("R10", 256'(int'(meta_valid) + int'(inl_valid) + int'(dsc_valid) + int'(cpl_valid) <= 1), 256'(1));
                if (m_st) chk("R9 meta", {meta_valid, mv}, {1'b1, m_hold});
                if (i_st) chk("R9 inl",  {inl_valid, iv},  {1'b1, i_hold});
                if (d_st) chk("R9 dsc",  {dsc_valid, dv},  {1'b1, d_hold});
                if (c_st) chk("R9 cpl",  {cpl_valid, cv},  {1'b1, c_hold});
                m_st = meta_valid && !meta_ready; m_hold = mv;
                i_st = inl_valid && !inl_ready;   i_hold = iv;
                d_st = dsc_valid && !dsc_ready;   d_hold = dv;
                c_st = cpl_valid && !cpl_ready;   c_hold = cv;
                if (cpl_valid) chk("R9 in_ready during completion", 256'(in_ready), 256'(0));
                if (meta_valid && meta_ready) begin
                    if (exp_meta.size() == 0) chk("R1 R7 unexpected meta", 256'(mv), 256'(0));
                    else chk("R1", 256'(mv), 256'(exp_meta.pop_front()));
                end
                if (inl_valid && inl_ready) begin
                    if (exp_inl.size() == 0) chk("R2 R7 unexpected inline", 256'(iv), 256'(0));
                    else chk("R2 R3", 256'(iv), 256'(exp_inl.pop_front()));
                end
                if (dsc_valid && dsc_ready) begin
                    if (exp_dsc.size() == 0) chk("R4 R7 unexpected desc", 256'(dv), 256'(0));
                    else chk("R4 R5", 256'(dv), 256'(exp_dsc.pop_front()));
                end
                if (cpl_valid && cpl_ready) begin
                    if (exp_cpl.size() == 0) chk("R6 unexpected completion", 256'(cv), 256'(0));
                    else chk("R6 R7", 256'(cv), 256'(exp_cpl.pop_front()));
                end
                accepted = in_valid && in_ready;
            end
        end
    end

    initial begin
        int id;
        int cyc;
        id = 1;
        add_entry(id++, 0, 0);                 // R8 header only
        add_entry(id++, 0, 2);                 // R8 no inline, descriptors only
        for (int il = 0; il <= 136; il++) add_entry(id++, il, il % 4);
        add_entry(id++, 129, 1);               // R7 oversized inline
        add_entry(id++, 200, 2);
        add_entry(id++, 255, 0);
        add_entry(id++, 255, 3);
        add_entry(id++, 130, 0);
        add_entry(id++, 5, 2);                 // R7 recovery after errors
        add_entry(id++, 128, 1);               // R3 full-word tail at the limit
        repeat (4) @(posedge clk);
        rst_n = 1'b1;
        @(negedge clk); #8;
        // R11 reset state
        chk("R11 in_ready", 256'(in_ready), 256'(1));
        chk("R11 valids", 256'({meta_valid, inl_valid, dsc_valid, cpl_valid}), 256'(0));
        run = 1;
        cyc = 0;
        while (!(idx >= words.size() && exp_cpl.size() == 0) && cyc < 150000) begin
            @(posedge clk); cyc++;
        end
        if (cyc >= 150000) begin
            fails++; checks++;
            $display("FAIL watchdog expired idx=%0d exp=%0d", idx, words.size());
        end
        repeat (4) @(posedge clk);
        chk("R1 leftover meta", 256'(exp_meta.size()), 256'(0));
        chk("R2 leftover inline", 256'(exp_inl.size()), 256'(0));
        chk("R4 leftover desc", 256'(exp_dsc.size()), 256'(0));
        chk("R6 leftover completion", 256'(exp_cpl.size()), 256'(0));
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule